// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block collects every reset cause of a bridge-style device and turns them into three reset outputs that differ in what they clear. It handles five causes. Power-good and a hot-reset pin arrive asynchronously. A link reset request arrives as a pulse from the upstream link logic. A software write that sets the secondary-bus-reset bit arrives as a one-cycle pulse, and so does a write that changes the bus frequency. The cold class, power-good low, clears persistent ("sticky") error state. The warm classes keep it. The software and frequency-change causes reach only the downstream bus.

Resets are asserted at once and released on a clock edge after a synchroniser of `SYNC_STAGES` flops. A link request holds the core in reset for `LINK_RST_CYC` cycles. The downstream bus reset is held for at least `BUS_RST_CYC` cycles after each bus cause, and a new cause arriving during that time restarts the count. When the stretch mode is enabled, the bus reset also stays asserted for `BUS_RST_CYC` cycles after the release that follows power-good. A link-down flag tells the upstream side when a power-good or pin reset is in progress. A safe-output enable drops while any reset is active.

Top module: `rst_seq_ctrl`

## Requirements
- R1: `rst_sticky_o` is 1 without waiting for a clock whenever `pwr_good_i` is 0. It returns to 0 on the `SYNC_STAGES`-th rising clock edge after `pwr_good_i` goes to 1.
- R2: `rst_core_o` is 1 without waiting for a clock whenever `pwr_good_i` is 0 or `hot_rst_n_i` is 0. It returns to 0 on the `SYNC_STAGES`-th rising edge after both inputs are 1, provided no link reset is running.
- R3: While `pwr_good_i` stays 1, `rst_sticky_o` stays 0. The hot-reset pin, link requests, bus-reset writes and frequency-change writes all leave it at 0.
- R4: A `link_rst_req_i` pulse that is sampled high on edge A sets `rst_core_o` to 1 from edge A+`SYNC_STAGES` for exactly `LINK_RST_CYC` cycles. `link_down_o` stays 0 throughout.
- R5: `link_down_o` is 1 exactly when the power-good or hot-pin core reset is in effect. It follows the same assertion and release timing as R2.
- R6: A `sbr_set_i` pulse that is sampled on edge P sets `rst_bus_o` to 1 from edge P for exactly `BUS_RST_CYC` cycles. `rst_core_o` is not affected.
- R7: A `freq_chg_i` pulse gives the same downstream-only bus reset as R6.
- R8: A bus cause that is sampled g cycles after an earlier one, while the count is still running, restarts the count. The bus reset then lasts g+`BUS_RST_CYC` cycles in total.
- R9: If `stretch_en_i` is 1, `rst_bus_o` stays 1 for `BUS_RST_CYC` cycles after `rst_sticky_o` is released. If it is 0, `rst_bus_o` is released together with the core reset. A hot-pin release gives no stretch.
- R10: `rst_bus_o` is 1 whenever `rst_core_o` is 1.
- R11: `safe_oe_o` is 0 whenever any of `rst_sticky_o`, `rst_core_o` or `rst_bus_o` is 1, and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| pwr_good_i | input | 1 | Power-good, asynchronous, 1 means supplies stable |
| hot_rst_n_i | input | 1 | Hot-reset pin, asynchronous, active low |
| link_rst_req_i | input | 1 | Link reset request pulse from the upstream link |
| sbr_set_i | input | 1 | One-cycle pulse: software set the secondary-bus-reset bit |
| freq_chg_i | input | 1 | One-cycle pulse: command write with a frequency change |
| stretch_en_i | input | 1 | Bus mode that stretches the bus reset after power-up |
| rst_sticky_o | output | 1 | Reset for persistent error state (cold only) |
| rst_core_o | output | 1 | Reset for all non-persistent logic |
| rst_bus_o | output | 1 | Downstream bus reset |
| link_down_o | output | 1 | Tells the upstream interface that the link is down |
| safe_oe_o | output | 1 | Output enable, 0 while any reset is active |

## Verification
The bench builds the block with `SYNC_STAGES`=2, `BUS_RST_CYC`=20 and `LINK_RST_CYC`=6. A full stretch window and a full link reset therefore fit into a few dozen cycles and can be counted edge by edge. It also exercises restart gaps of 1 cycle and of `BUS_RST_CYC`-1 cycles, which shows that the count reloads and does not add up, right up to the last cycle of a running window. The stretch mode is applied with both settings of `stretch_en_i`, and a hot-pin release is included to show that only the power-good release arms the stretch.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef struct packed {
    logic sticky;
    logic core;
    logic bus;
  } rst_vec_t;

endpackage

// File: rtl/rst_sync_chain.sv
module rst_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_i,
  output logic rst_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b0};
  end

  assign rst_o = chain_q[STAGES-1];

endmodule

// File: rtl/rst_pulse_timer.sv
module rst_pulse_timer #(
  parameter int unsigned CYC = 16
) (
  input  logic clk_i,
  input  logic srst_i,
  input  logic arm_i,
  input  logic start_i,
  output logic busy_o
);

  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (srst_i)              cnt_q <= arm_i ? CW'(CYC) : '0;
    else if (start_i)        cnt_q <= CW'(CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R6: a start always leads to a busy window
  a_r6_start_busy: assert property (@(posedge clk_i) disable iff (srst_i)
    start_i |=> busy_o);

  // R8: a window ends only after its last cycle or through a reset
  a_r8_full_count: assert property (@(posedge clk_i) disable iff (srst_i)
    $fell(busy_o) |-> ($past(cnt_q) == CW'(1) || $past(srst_i)));

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned BUS_RST_CYC  = 500000,
  parameter int unsigned LINK_RST_CYC = 64
) (
  input  logic clk_i,
  input  logic pwr_good_i,
  input  logic hot_rst_n_i,
  input  logic link_rst_req_i,
  input  logic sbr_set_i,
  input  logic freq_chg_i,
  input  logic stretch_en_i,
  output logic rst_sticky_o,
  output logic rst_core_o,
  output logic rst_bus_o,
  output logic link_down_o,
  output logic safe_oe_o
);

  logic cold_arst, warm_arst;
  logic cold_sync, warm_sync;
  logic link_go, link_busy, bus_busy;
  logic [SYNC_STAGES-1:0] lreq_q;
  rst_vec_t rv;

  assign cold_arst = !pwr_good_i;
  assign warm_arst = !pwr_good_i || !hot_rst_n_i;

  rst_sync_chain #(.STAGES(SYNC_STAGES)) u_cold_sync (
    .clk_i  (clk_i),
    .arst_i (cold_arst),
    .rst_o  (cold_sync)
  );

  rst_sync_chain #(.STAGES(SYNC_STAGES)) u_warm_sync (
    .clk_i  (clk_i),
    .arst_i (warm_arst),
    .rst_o  (warm_sync)
  );

  // link request crosses through its own flop chain
  always_ff @(posedge clk_i) begin
    if (warm_sync) lreq_q <= '0;
    else           lreq_q <= {lreq_q[SYNC_STAGES-2:0], link_rst_req_i};
  end
  assign link_go = lreq_q[SYNC_STAGES-1];

  rst_pulse_timer #(.CYC(LINK_RST_CYC)) u_link_tmr (
    .clk_i   (clk_i),
    .srst_i  (warm_sync),
    .arm_i   (1'b0),
    .start_i (link_go),
    .busy_o  (link_busy)
  );

  rst_pulse_timer #(.CYC(BUS_RST_CYC)) u_bus_tmr (
    .clk_i   (clk_i),
    .srst_i  (cold_sync),
    .arm_i   (stretch_en_i),
    .start_i (sbr_set_i || freq_chg_i),
    .busy_o  (bus_busy)
  );

  always_comb begin
    rv.sticky = cold_sync;
    rv.core   = warm_sync || link_busy;
    rv.bus    = rv.core || bus_busy;
  end

  assign rst_sticky_o = rv.sticky;
  assign rst_core_o   = rv.core;
  assign rst_bus_o    = rv.bus;
  assign link_down_o  = warm_sync;
  assign safe_oe_o    = !(|rv);

  // R1: the sticky reset is released only while power is good
  a_r1_sticky_release: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    $fell(rst_sticky_o) |-> $past(pwr_good_i));

  // R2: the core reset is never released before the sticky reset
  a_r2_core_covers_sticky: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    rst_sticky_o |-> rst_core_o);

  // R3: with power good, the sticky reset never re-asserts
  a_r3_sticky_kept: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    !rst_sticky_o |=> !rst_sticky_o);

  // R5: link-down implies a full core and bus reset
  a_r5_link_down_core: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    link_down_o |-> (rst_core_o && rst_bus_o));

  // R10: the bus is reset whenever the core is
  a_r10_bus_covers_core: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    rst_core_o |-> rst_bus_o);

  // R11: outputs are parked while any reset is active
  a_r11_safe_oe: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    (rst_core_o || rst_bus_o || rst_sticky_o) |-> !safe_oe_o);

endmodule

// File: tb/rst_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rst_seq_ctrl_tb_top;

  localparam int SS = 2;
  localparam int BN = 20;
  localparam int LN = 6;

  // {first cause, second cause, gap, expected length}; cause 0 = sbr, 1 = freq
  localparam logic [25:0] VECS [0:4] = '{
    {1'b0, 1'b0, 8'd0,  16'(BN)},
    {1'b1, 1'b0, 8'd0,  16'(BN)},
    {1'b0, 1'b1, 8'd5,  16'(BN + 5)},
    {1'b1, 1'b1, 8'(BN - 1), 16'(BN + BN - 1)},
    {1'b0, 1'b0, 8'd1,  16'(BN + 1)}
  };

  logic clk = 1'b0;
  logic pg = 1'b1, hot_n = 1'b1, lreq = 1'b0, sbr = 1'b0, frq = 1'b0, stretch = 1'b1;
  logic r_sticky, r_core, r_bus, ldown, soe;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  rst_seq_ctrl #(.SYNC_STAGES(SS), .BUS_RST_CYC(BN), .LINK_RST_CYC(LN)) dut_i (
    .clk_i(clk), .pwr_good_i(pg), .hot_rst_n_i(hot_n), .link_rst_req_i(lreq),
    .sbr_set_i(sbr), .freq_chg_i(frq), .stretch_en_i(stretch),
    .rst_sticky_o(r_sticky), .rst_core_o(r_core), .rst_bus_o(r_bus),
    .link_down_o(ldown), .safe_oe_o(soe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cause(input logic c, input logic v);
    if (c) frq = v; else sbr = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int len, bad;
    #1 pg = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 sticky in reset", r_sticky, 1);
    check("R2 core in reset", r_core, 1);
    check("R10 bus in reset", r_bus, 1);
    check("R5 link down in reset", ldown, 1);
    check("R11 safe_oe in reset", soe, 0);

    // power-good release with stretch
    pg = 1'b1;
    @(negedge clk);
    check("R1 sticky held one edge", r_sticky, 1);
    @(negedge clk);
    check("R1 sticky released", r_sticky, 0);
    check("R2 core released", r_core, 0);
    check("R5 link down released", ldown, 0);
    check("R11 safe_oe during stretch", soe, 0);
    len = 0;
    while (r_bus && len < 1000) begin len++; @(negedge clk); end
    check("R9 stretch length", len, BN);
    check("R11 safe_oe after release", soe, 1);

    // bus-cause vectors: R6 R7 R8
    for (int i = 0; i < 5; i++) begin
      logic c1, c2;
      int gap, exp;
      c1 = VECS[i][25]; c2 = VECS[i][24];
      gap = int'(VECS[i][23:16]); exp = int'(VECS[i][15:0]);
      set_cause(c1, 1'b1);
      @(negedge clk);
      set_cause(c1, 1'b0);
      len = 0; bad = 0;
      while (r_bus && len < 1000) begin
        if (r_core || r_sticky || ldown) bad++;
        len++;
        if (gap != 0 && len == gap) set_cause(c2, 1'b1);
        @(negedge clk);
        sbr = 1'b0; frq = 1'b0;
      end
      check(c1 ? "R7 freq bus length" : "R6 sbr bus length", len, exp);
      check("R8 R3 bus only, core and sticky idle", bad, 0);
    end

    // hot-reset pin
    @(negedge clk);
    hot_n = 1'b0;
    #1;
    check("R2 core async on pin", r_core, 1);
    check("R5 link down on pin", ldown, 1);
    check("R3 sticky untouched by pin", r_sticky, 0);
    check("R10 bus follows pin", r_bus, 1);
    repeat (2) @(negedge clk);
    hot_n = 1'b1;
    @(negedge clk);
    check("R2 core held one edge", r_core, 1);
    @(negedge clk);
    check("R2 core released after pin", r_core, 0);
    check("R9 no stretch after pin", r_bus, 0);
    check("R5 link down released after pin", ldown, 0);

    // link request pulse
    lreq = 1'b1;
    @(negedge clk);
    lreq = 1'b0;
    bad = 0;
    if (r_core) bad++;
    @(negedge clk);
    if (r_core) bad++;
    check("R4 link sync delay", bad, 0);
    @(negedge clk);
    len = 0; bad = 0;
    while (r_core && len < 1000) begin
      if (ldown || r_sticky || !r_bus) bad++;
      len++; @(negedge clk);
    end
    check("R4 link reset length", len, LN);
    check("R4 R3 R10 link side effects", bad, 0);

    // power-good cycle without stretch
    stretch = 1'b0;
    pg = 1'b0;
    #1;
    check("R1 sticky async on power loss", r_sticky, 1);
    check("R11 safe_oe async on power loss", soe, 0);
    @(negedge clk);
    pg = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 sticky released again", r_sticky, 0);
    check("R9 no stretch when disabled", r_bus, 0);
    check("R11 safe_oe restored", soe, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule